// File: doc/BRIEF.md
# Speculative Separable Switch Allocator

This block decides, in every cycle, which waiting flit at each router input port crosses the crossbar and which input port drives each output port. Two allocations run side by side. One serves input virtual channels that already own an output VC; these are called settled requests. The other serves input VCs that are asking the VC allocator for an output VC in this same cycle; these are called speculative requests. Each allocation is separable. A round-robin pick among the VCs of one input port comes first. A round-robin pick among the contending input ports at each output port follows. The grants are produced combinationally in the cycle the requests appear.

The two results are then merged. A settled grant beats a speculative one that collides with it on the same input port or the same output port. A speculative grant whose VC request failed this cycle is withdrawn, and that crossbar slot stays idle. Each round-robin pointer moves past its winner only when the grant it produced is really issued. The matching is not required to be maximal.

Top module: `swalloc_top`

## Requirements
- R1: After reset, every round-robin pointer starts at index 0: the first grant at an input goes to its lowest-numbered requesting VC, and the first grant at an output goes to its lowest-numbered requesting input.
- R2: In any cycle, each input port receives at most one grant and each output port is driven by at most one input.
- R3: A grant at input i names a VC v (flat request index i*NUM_VCS+v) that is requesting. The grant's destination equals that VC's requested destination d. The crossbar select of output d is valid and names i, in the same cycle.
- R4: Among the requesting VCs of one input port in one class, the winner is chosen round-robin. After a used grant to VC v, the search starts at v+1.
- R5: Among the inputs contending for one output in one class, the winner is chosen round-robin. After a used grant to input i, the search starts at i+1.
- R6: When an input port holds a settled grant, no speculative grant is issued at that input.
- R7: When an output port is granted to a settled request, a speculative request to that output gets no grant.
- R8: A speculative grant is issued only if the VC-allocation success flag of its VC is 1. Otherwise it is withdrawn and the output stays idle unless a settled request takes it.
- R9: A withdrawn or overridden grant does not move any pointer, so the same VC wins again in the next cycle.
- R10: With no request bits set, no grant and no crossbar select is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the pointers |
| req_valid | input | NUM_PORTS*NUM_VCS | Request bit per input VC, index port*NUM_VCS+vc |
| req_spec | input | NUM_PORTS*NUM_VCS | 1 = speculative request, 0 = settled (VC already owned) |
| req_dest | input | NUM_PORTS*NUM_VCS*PW | Requested output port per input VC |
| vca_ok | input | NUM_PORTS*NUM_VCS | VC allocation succeeded this cycle, per input VC |
| gnt_valid | output | NUM_PORTS | Grant issued at each input port |
| gnt_vc | output | NUM_PORTS*VW | Winning VC at each input port |
| gnt_dest | output | NUM_PORTS*PW | Output port granted to each input port |
| xbar_valid | output | NUM_PORTS | Crossbar select valid per output port |
| xbar_src | output | NUM_PORTS*PW | Input port selected per output port |

## Verification
The bench goes after collisions between the two classes. In one case a settled and a speculative request share an input, and a design without input-side priority would grant both or grant the wrong one. In the other they share an output, and a design without output-side priority would drive two inputs onto one output. It withdraws a speculative grant through a failed VC flag and then offers a competing VC. A design that advanced a pointer on a withdrawn grant would hand the next slot to the wrong VC. A behavioural model with its own pointers compares every output each cycle through long mixed random traffic, which exposes pointer drift and double grants.

// File: rtl/swalloc_pkg.sv
package swalloc_pkg;
  // index width for a set of n items, never narrower than one bit
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // next round-robin start after a winner at position w of n
  function automatic int rr_next(input int w, input int n);
    return (w + 1) % n;
  endfunction
endpackage

// File: rtl/swalloc_rr.sv
module swalloc_rr
  import swalloc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          found,
  output logic [idx_width(N)-1:0] idx
);
  localparam int IW = idx_width(N);

  logic [IW-1:0] ptr;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = (int'(ptr) + k) % N;
      if (!found && req[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (adv && found)
      ptr <= IW'(rr_next(int'(idx), N));
  end
endmodule

// File: rtl/swalloc_path.sv
module swalloc_path
  import swalloc_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_VCS   = 2,
  localparam int PW = idx_width(NUM_PORTS),
  localparam int VW = idx_width(NUM_VCS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS*NUM_VCS-1:0]      req,
  input  logic [NUM_PORTS*NUM_VCS*PW-1:0]   dest,
  input  logic [NUM_PORTS-1:0]              in_adv,
  input  logic [NUM_PORTS-1:0]              out_adv,
  output logic [NUM_PORTS-1:0]              s1_found,
  output logic [NUM_PORTS*VW-1:0]           s1_vc,
  output logic [NUM_PORTS*PW-1:0]           s1_dest,
  output logic [NUM_PORTS-1:0]              out_found,
  output logic [NUM_PORTS*PW-1:0]           out_src,
  output logic [NUM_PORTS-1:0]              in_won
);
  // stage one: pick a VC per input port
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
    logic [PW-1:0] d_sel;
    swalloc_rr #(.N(NUM_VCS)) u_vc_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req[i*NUM_VCS +: NUM_VCS]),
      .adv   (in_adv[i]),
      .found (s1_found[i]),
      .idx   (s1_vc[i*VW +: VW])
    );
    always_comb begin
      d_sel = '0;
      for (int v = 0; v < NUM_VCS; v++)
        if (s1_vc[i*VW +: VW] == VW'(v))
          d_sel = dest[(i*NUM_VCS + v)*PW +: PW];
    end
    assign s1_dest[i*PW +: PW] = d_sel;
  end

  // stage two: pick an input port per output port
  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    logic [NUM_PORTS-1:0] oreq;
    always_comb
      for (int j = 0; j < NUM_PORTS; j++)
        oreq[j] = s1_found[j] && (s1_dest[j*PW +: PW] == PW'(o));
    swalloc_rr #(.N(NUM_PORTS)) u_port_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (oreq),
      .adv   (out_adv[o]),
      .found (out_found[o]),
      .idx   (out_src[o*PW +: PW])
    );
  end

  always_comb begin
    in_won = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      for (int o = 0; o < NUM_PORTS; o++)
        if (out_found[o] && out_src[o*PW +: PW] == PW'(i))
          in_won[i] = 1'b1;
  end
endmodule

// File: rtl/swalloc_top.sv
module swalloc_top
  import swalloc_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_VCS   = 2,
  localparam int PW = idx_width(NUM_PORTS),
  localparam int VW = idx_width(NUM_VCS),
  localparam int NIV = NUM_PORTS * NUM_VCS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIV-1:0]       req_valid,
  input  logic [NIV-1:0]       req_spec,
  input  logic [NIV*PW-1:0]    req_dest,
  input  logic [NIV-1:0]       vca_ok,
  output logic [NUM_PORTS-1:0]      gnt_valid,
  output logic [NUM_PORTS*VW-1:0]   gnt_vc,
  output logic [NUM_PORTS*PW-1:0]   gnt_dest,
  output logic [NUM_PORTS-1:0]      xbar_valid,
  output logic [NUM_PORTS*PW-1:0]   xbar_src
);
  // per-class results, index 0 settled, index 1 speculative
  logic [NUM_PORTS-1:0]    s1_found [2];
  logic [NUM_PORTS*VW-1:0] s1_vc    [2];
  logic [NUM_PORTS*PW-1:0] s1_dest  [2];
  logic [NUM_PORTS-1:0]    o_found  [2];
  logic [NUM_PORTS*PW-1:0] o_src    [2];
  logic [NUM_PORTS-1:0]    i_won    [2];
  logic [NUM_PORTS-1:0]    i_adv    [2];
  logic [NUM_PORTS-1:0]    o_adv    [2];

  // events named for the checker
  logic [NUM_PORTS-1:0] spec_drop_prio;  // speculative winner beaten by a settled grant
  logic [NUM_PORTS-1:0] spec_drop_vca;   // speculative winner whose VC request failed
  logic [NUM_PORTS-1:0] spec_take;       // speculative output grant issued
  logic [NUM_PORTS-1:0] spec_keep;       // speculative input grant issued

  for (genvar c = 0; c < 2; c++) begin : g_cls
    logic [NIV-1:0] cls_req;
    assign cls_req = (c == 0) ? (req_valid & ~req_spec) : (req_valid & req_spec);
    swalloc_path #(.NUM_PORTS(NUM_PORTS), .NUM_VCS(NUM_VCS)) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (cls_req),
      .dest      (req_dest),
      .in_adv    (i_adv[c]),
      .out_adv   (o_adv[c]),
      .s1_found  (s1_found[c]),
      .s1_vc     (s1_vc[c]),
      .s1_dest   (s1_dest[c]),
      .out_found (o_found[c]),
      .out_src   (o_src[c]),
      .in_won    (i_won[c])
    );
  end

  // merge at each output: settled first, speculative only if unopposed and backed
  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++) begin
      logic blk, ok;
      blk = o_found[0][o];
      ok  = 1'b0;
      for (int j = 0; j < NUM_PORTS; j++)
        if (o_src[1][o*PW +: PW] == PW'(j)) begin
          blk = blk || i_won[0][j];
          for (int v = 0; v < NUM_VCS; v++)
            if (s1_vc[1][j*VW +: VW] == VW'(v))
              ok = vca_ok[j*NUM_VCS + v];
        end
      spec_drop_prio[o] = o_found[1][o] && blk;
      spec_drop_vca[o]  = o_found[1][o] && !ok;
      spec_take[o]      = o_found[1][o] && !blk && ok;
    end
  end

  always_comb begin
    spec_keep = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      for (int o = 0; o < NUM_PORTS; o++)
        if (spec_take[o] && o_src[1][o*PW +: PW] == PW'(i))
          spec_keep[i] = 1'b1;
  end

  // pointers move only on issued grants
  assign i_adv[0] = i_won[0];
  assign o_adv[0] = o_found[0];
  assign i_adv[1] = spec_keep;
  assign o_adv[1] = spec_take;

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      gnt_valid[i] = i_won[0][i] || spec_keep[i];
      if (i_won[0][i]) begin
        gnt_vc[i*VW +: VW]   = s1_vc[0][i*VW +: VW];
        gnt_dest[i*PW +: PW] = s1_dest[0][i*PW +: PW];
      end else begin
        gnt_vc[i*VW +: VW]   = spec_keep[i] ? s1_vc[1][i*VW +: VW] : '0;
        gnt_dest[i*PW +: PW] = spec_keep[i] ? s1_dest[1][i*PW +: PW] : '0;
      end
    end
    for (int o = 0; o < NUM_PORTS; o++) begin
      xbar_valid[o] = o_found[0][o] || spec_take[o];
      if (o_found[0][o])
        xbar_src[o*PW +: PW] = o_src[0][o*PW +: PW];
      else
        xbar_src[o*PW +: PW] = spec_take[o] ? o_src[1][o*PW +: PW] : '0;
    end
  end
endmodule

// File: rtl/swalloc_chk.sv
module swalloc_chk
  import swalloc_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_VCS   = 2,
  localparam int PW = idx_width(NUM_PORTS),
  localparam int VW = idx_width(NUM_VCS),
  localparam int NIV = NUM_PORTS * NUM_VCS
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NIV-1:0]          req_valid,
  input logic [NIV-1:0]          req_spec,
  input logic [NIV*PW-1:0]       req_dest,
  input logic [NIV-1:0]          vca_ok,
  input logic [NUM_PORTS-1:0]    gnt_valid,
  input logic [NUM_PORTS*VW-1:0] gnt_vc,
  input logic [NUM_PORTS*PW-1:0] gnt_dest,
  input logic [NUM_PORTS-1:0]    xbar_valid,
  input logic [NUM_PORTS*PW-1:0] xbar_src,
  input logic [NUM_PORTS-1:0]    spec_drop_vca,
  input logic [NUM_PORTS-1:0]    spec_take
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_i
    logic sel_req, sel_spec, sel_ok, sel_xbar;
    logic [PW-1:0] sel_dest;
    always_comb begin
      sel_req = 1'b0; sel_spec = 1'b0; sel_ok = 1'b0; sel_dest = '0; sel_xbar = 1'b0;
      for (int v = 0; v < NUM_VCS; v++)
        if (gnt_vc[i*VW +: VW] == VW'(v)) begin
          sel_req  = req_valid[i*NUM_VCS + v];
          sel_spec = req_spec[i*NUM_VCS + v];
          sel_ok   = vca_ok[i*NUM_VCS + v];
          sel_dest = req_dest[(i*NUM_VCS + v)*PW +: PW];
        end
      for (int o = 0; o < NUM_PORTS; o++)
        if (gnt_dest[i*PW +: PW] == PW'(o))
          sel_xbar = xbar_valid[o] && (xbar_src[o*PW +: PW] == PW'(i));
    end

    assert_grant_consistent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[i] |-> (sel_req && sel_dest == gnt_dest[i*PW +: PW] && sel_xbar));

    assert_spec_backed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid[i] && sel_spec) |-> sel_ok);
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_o
    logic [NUM_PORTS-1:0] hits;
    always_comb
      for (int i = 0; i < NUM_PORTS; i++)
        hits[i] = gnt_valid[i] && (gnt_dest[i*PW +: PW] == PW'(o));

    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hits) && (xbar_valid[o] == (|hits)));

    assert_vca_fail_no_spec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      spec_drop_vca[o] |-> !spec_take[o]);
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> (gnt_valid == '0 && xbar_valid == '0));
endmodule

bind swalloc_top swalloc_chk #(.NUM_PORTS(NUM_PORTS), .NUM_VCS(NUM_VCS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_spec      (req_spec),
  .req_dest      (req_dest),
  .vca_ok        (vca_ok),
  .gnt_valid     (gnt_valid),
  .gnt_vc        (gnt_vc),
  .gnt_dest      (gnt_dest),
  .xbar_valid    (xbar_valid),
  .xbar_src      (xbar_src),
  .spec_drop_vca (spec_drop_vca),
  .spec_take     (spec_take)
);

// File: tb/tb_swalloc_top.sv
module tb_swalloc_top;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 5;
  localparam int V  = 2;
  localparam int PW = (P > 1) ? $clog2(P) : 1;
  localparam int VW = (V > 1) ? $clog2(V) : 1;
  localparam int NIV = P * V;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NIV-1:0]    rv = '0, rs = '0, ok = '0;
  logic [NIV*PW-1:0] rd = '0;
  logic [P-1:0]      gnt_valid, xbar_valid;
  logic [P*VW-1:0]   gnt_vc;
  logic [P*PW-1:0]   gnt_dest, xbar_src;

  int total = 0;
  int bad = 0;

  // model state: pointers per class (0 settled, 1 speculative)
  int ip [2][P];
  int op [2][P];
  int w1 [2][P];
  int w2 [2][P];
  int e_gv [P], e_gc [P], e_gd [P], e_gcls [P];
  int e_xv [P], e_xs [P], e_xcls [P];

  always #(CLK_PERIOD/2) clk = ~clk;

  swalloc_top #(.NUM_PORTS(P), .NUM_VCS(V)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_spec(rs), .req_dest(rd),
    .vca_ok(ok), .gnt_valid(gnt_valid), .gnt_vc(gnt_vc), .gnt_dest(gnt_dest),
    .xbar_valid(xbar_valid), .xbar_src(xbar_src)
  );

  function automatic int dst(int i, int v);
    return int'(rd[(i*V + v)*PW +: PW]);
  endfunction

  task automatic clr();
    rv = '0; rs = '0; ok = '0; rd = '0;
  endtask

  task automatic put(int i, int v, bit spec, int d, bit okv);
    rv[i*V+v] = 1'b1; rs[i*V+v] = spec; ok[i*V+v] = okv;
    rd[(i*V+v)*PW +: PW] = PW'(d);
  endtask

  task automatic model();
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < P; i++) begin
        w1[c][i] = -1;
        for (int k = 0; k < V; k++) begin
          int v = (ip[c][i] + k) % V;
          if (w1[c][i] < 0 && rv[i*V+v] && (int'(rs[i*V+v]) == c)) w1[c][i] = v;
        end
      end
      for (int o = 0; o < P; o++) begin
        w2[c][o] = -1;
        for (int k = 0; k < P; k++) begin
          int i = (op[c][o] + k) % P;
          if (w2[c][o] < 0 && w1[c][i] >= 0 && dst(i, w1[c][i]) == o) w2[c][o] = i;
        end
      end
    end
    for (int i = 0; i < P; i++) begin e_gv[i] = 0; e_gc[i] = 0; e_gd[i] = 0; e_gcls[i] = -1; end
    for (int o = 0; o < P; o++) begin
      e_xv[o] = 0; e_xs[o] = 0; e_xcls[o] = -1;
      if (w2[0][o] >= 0) begin
        int i = w2[0][o];
        e_xv[o] = 1; e_xs[o] = i; e_xcls[o] = 0;
        e_gv[i] = 1; e_gc[i] = w1[0][i]; e_gd[i] = o; e_gcls[i] = 0;
      end
    end
    for (int o = 0; o < P; o++) begin
      if (w2[1][o] >= 0 && e_xv[o] == 0) begin
        int i = w2[1][o];
        if (e_gcls[i] != 0 && ok[i*V + w1[1][i]]) begin
          e_xv[o] = 1; e_xs[o] = i; e_xcls[o] = 1;
          e_gv[i] = 1; e_gc[i] = w1[1][i]; e_gd[i] = o; e_gcls[i] = 1;
        end
      end
    end
  endtask

  task automatic advance();
    for (int i = 0; i < P; i++)
      if (e_gcls[i] >= 0) ip[e_gcls[i]][i] = (e_gc[i] + 1) % V;
    for (int o = 0; o < P; o++)
      if (e_xcls[o] >= 0) op[e_xcls[o]][o] = (e_xs[o] + 1) % P;
  endtask

  task automatic cmp(string tag);
    total++;
    for (int i = 0; i < P; i++) begin
      if (int'(gnt_valid[i]) != e_gv[i] ||
          (e_gv[i] != 0 && (int'(gnt_vc[i*VW +: VW]) != e_gc[i] ||
                            int'(gnt_dest[i*PW +: PW]) != e_gd[i]))) begin
        bad++;
        $display("FAIL %s input %0d: got v=%0d vc=%0d d=%0d exp v=%0d vc=%0d d=%0d", tag, i,
                 gnt_valid[i], gnt_vc[i*VW +: VW], gnt_dest[i*PW +: PW], e_gv[i], e_gc[i], e_gd[i]);
        return;
      end
    end
    for (int o = 0; o < P; o++) begin
      if (int'(xbar_valid[o]) != e_xv[o] ||
          (e_xv[o] != 0 && int'(xbar_src[o*PW +: PW]) != e_xs[o])) begin
        bad++;
        $display("FAIL %s output %0d: got v=%0d src=%0d exp v=%0d src=%0d", tag, o,
                 xbar_valid[o], xbar_src[o*PW +: PW], e_xv[o], e_xs[o]);
        return;
      end
    end
  endtask

  task automatic expect_int(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d exp %0d", tag, act, exp);
    end
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic step(string tag);
    #1; model(); cmp(tag);
    @(posedge clk); advance();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: got hang exp finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < P; k++) begin ip[c][k] = 0; op[c][k] = 0; end
    clr();
    repeat (3) @(negedge clk);
    #1;
    // R10 / R1: quiet outputs with nothing requested
    expect_int("R10 idle grants", int'(gnt_valid), 0);
    expect_int("R10 idle xbar", int'(xbar_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R4: two settled VCs on input 0 toward output 1
    put(0, 0, 1'b0, 1, 1'b0); put(0, 1, 1'b0, 1, 1'b0);
    #1 expect_int("R1 first vc after reset", int'(gnt_vc[0 +: VW]), 0);
    step("R4");
    #1 expect_int("R4 rotate to vc1", int'(gnt_vc[0 +: VW]), 1);
    step("R4");
    #1 expect_int("R4 wrap to vc0", int'(gnt_vc[0 +: VW]), 0);
    step("R4");

    // R5: inputs 0..2 contend for output 3
    clr();
    put(0, 0, 1'b0, 3, 1'b0); put(1, 0, 1'b0, 3, 1'b0); put(2, 0, 1'b0, 3, 1'b0);
    for (int k = 0; k < 3; k++) begin
      #1 expect_int("R5 output rotation", int'(xbar_src[3*PW +: PW]), k);
      step("R5");
    end

    // R6: settled and speculative on the same input
    clr();
    put(0, 0, 1'b0, 1, 1'b0); put(0, 1, 1'b1, 2, 1'b1);
    #1 expect_int("R6 settled vc wins input", int'(gnt_vc[0 +: VW]), 0);
    expect_int("R6 spec output idle", int'(xbar_valid[2]), 0);
    step("R6");

    // R7: settled and speculative on the same output
    clr();
    put(0, 0, 1'b0, 2, 1'b0); put(1, 0, 1'b1, 2, 1'b1);
    #1 expect_int("R7 settled input drives output", int'(xbar_src[2*PW +: PW]), 0);
    expect_int("R7 spec input denied", int'(gnt_valid[1]), 0);
    step("R7");

    // R8: speculative grant withdrawn on VC failure
    clr();
    put(3, 0, 1'b1, 0, 1'b0);
    #1 expect_int("R8 withdrawn grant", int'(gnt_valid[3]), 0);
    expect_int("R8 slot wasted", int'(xbar_valid[0]), 0);
    step("R8");
    // R9: pointer unmoved, vc0 still first
    put(3, 0, 1'b1, 0, 1'b1); put(3, 1, 1'b1, 0, 1'b1);
    #1 expect_int("R9 pointer held", int'(gnt_vc[3*VW +: VW]), 0);
    expect_int("R8 backed grant issued", int'(gnt_valid[3]), 1);
    step("R9");

    // R2 / R3: mixed random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      clr();
      for (int i = 0; i < P; i++)
        for (int v = 0; v < V; v++)
          if ($urandom_range(0, 2) != 0)
            put(i, v, 1'($urandom_range(0, 1)), int'($urandom_range(0, P-1)), 1'($urandom_range(0, 3) != 0));
      step("R2 R3 random");
    end

    clr();
    step("R10");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule